// File: doc/BRIEF.md
# Fetch-and-Add Scatter Unit

The block is a vector scatter engine that sits in front of a small single-port local memory. Each instruction carries a base address, a stride, an index per lane, an addend per lane, a lane enable mask and a flag that selects a returning or a plain flavour. For every enabled lane the unit reads the word at `base + index*stride`, adds the lane's addend and writes the sum back. The returning flavour hands back, per lane, the word as it was before that lane's add. The plain flavour leaves its result output at zero.

The memory does one read-modify-write per cycle, so lanes are processed one after another in ascending lane order. The unit is busy while lanes remain. Lanes of one vector that hit the same word are therefore resolved one at a time: a later lane sees the sums left by earlier lanes. Every such same-address match bumps a running conflict counter. Instructions offered while the unit is busy are ignored, so accepted instructions take effect strictly in the order they were accepted. Reading the memory is done through the unit itself, with a returning instruction whose addends are zero.

Top module: `fadd_scatter`

## Requirements
- R1: The word touched by an enabled lane is at `(issue_base + idx*issue_stride) mod 2^AW`, where lane l's index is `issue_idx[l*IW +: IW]` and its addend `issue_addend[l*DW +: DW]`; that word gains the addend.
- R2: A lane whose `issue_mask` bit is 0 leaves the memory unchanged and its slice of `ret_data` is zero.
- R3: With `issue_ret` = 1, `ret_valid` and `done` rise together and `ret_data[l*DW +: DW]` holds the word lane l read before its own add.
- R4: With `issue_ret` = 0, the memory is still updated, `ret_valid` stays 0 and `ret_data` is all zero at `done`.
- R5: Enabled lanes commit in ascending lane order; a lane that hits a word already touched in the same vector returns a value that includes the earlier lanes' addends.
- R6: An accepted instruction with k enabled lanes holds `busy` high for exactly max(k,1) cycles, and `done` pulses for one cycle as `busy` falls.
- R7: At acceptance, `conflict_count` grows by the number of enabled lanes whose word equals that of some lower enabled lane; it wraps modulo 2^CW.
- R8: An instruction is accepted only while `busy` is 0; `issue_valid` during `busy` has no effect, and accepted instructions take effect in acceptance order.
- R9: The add wraps modulo 2^DW.
- R10: After reset `busy`, `done`, `ret_valid` and `conflict_count` are 0, and every memory word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Offer an instruction (taken when busy is 0) |
| issue_ret | input | 1 | 1 = returning flavour, 0 = plain |
| issue_base | input | AW | Base word address |
| issue_stride | input | SW | Stride applied to every index |
| issue_idx | input | LANES*IW | Per-lane index |
| issue_addend | input | LANES*DW | Per-lane addend |
| issue_mask | input | LANES | Per-lane enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse at completion |
| ret_valid | output | 1 | ret_data valid (returning flavour) |
| ret_data | output | LANES*DW | Per-lane pre-add values |
| conflict_count | output | CW | Running count of same-address matches |

## Verification
The two functions that meet in one cycle are conflict serialization and pre-add return: when several enabled lanes of a vector target one word, the cycle that commits a lane's sum is also the cycle that captures the next lane's pre-add value, so that value must already include the earlier sum. This is provoked by directed vectors with all lanes on one word, by masks that skip lanes between colliding ones, and by random vectors whose indices come from a narrow range so that collisions are frequent. The bench judges each run by a lane-ordered reference model that predicts every returned word, the conflict increment and the busy length, and then reads the whole memory back through zero-addend returning instructions.

// File: rtl/fadd_scatter.sv
module fadd_scatter #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int IW    = 8,
  parameter int SW    = 8,
  parameter int CW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  input  logic                issue_ret,
  input  logic [AW-1:0]       issue_base,
  input  logic [SW-1:0]       issue_stride,
  input  logic [LANES*IW-1:0] issue_idx,
  input  logic [LANES*DW-1:0] issue_addend,
  input  logic [LANES-1:0]    issue_mask,
  output logic                busy,
  output logic                done,
  output logic                ret_valid,
  output logic [LANES*DW-1:0] ret_data,
  output logic [CW-1:0]       conflict_count
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int XW    = AW + IW + SW;

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] b,
                                            input logic [SW-1:0] s,
                                            input logic [IW-1:0] i);
    logic [XW-1:0] p;
    p = XW'(b) + XW'(i) * XW'(s);
    return p[AW-1:0];
  endfunction

  logic [DW-1:0]       mem [DEPTH];
  logic                busy_r, done_r, retv_r, q_ret;
  logic [AW-1:0]       q_base;
  logic [SW-1:0]       q_stride;
  logic [LANES*IW-1:0] q_idx;
  logic [LANES*DW-1:0] q_add, ret_r;
  logic [LANES-1:0]    pend, pend_next;
  logic [CW-1:0]       cnt, new_conf;
  logic [LW-1:0]       cur;
  logic [AW-1:0]       cur_addr;
  logic [DW-1:0]       old_val, sum_val;
  logic [AW-1:0]       in_addr [LANES];

  wire accept = issue_valid && !busy_r;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      in_addr[l] = word_of(issue_base, issue_stride, issue_idx[l*IW +: IW]);
  end

  always_comb begin
    new_conf = '0;
    for (int j = 1; j < LANES; j++) begin
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < LANES; i++)
        if (i < j && issue_mask[i] && in_addr[i] == in_addr[j]) hit = 1'b1;
      if (issue_mask[j] && hit) new_conf = new_conf + CW'(1);
    end
  end

  always_comb begin
    cur = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (pend[l]) cur = LW'(l);
  end

  assign cur_addr  = word_of(q_base, q_stride, q_idx[int'(cur)*IW +: IW]);
  assign old_val   = mem[cur_addr];
  assign sum_val   = old_val + q_add[int'(cur)*DW +: DW];
  assign pend_next = pend & ~(LANES'(1) << cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (busy_r && pend != '0) begin
      mem[cur_addr] <= sum_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_r   <= 1'b0;
      done_r   <= 1'b0;
      retv_r   <= 1'b0;
      q_ret    <= 1'b0;
      q_base   <= '0;
      q_stride <= '0;
      q_idx    <= '0;
      q_add    <= '0;
      pend     <= '0;
      ret_r    <= '0;
      cnt      <= '0;
    end else begin
      done_r <= 1'b0;
      retv_r <= 1'b0;
      if (accept) begin
        busy_r   <= 1'b1;
        q_ret    <= issue_ret;
        q_base   <= issue_base;
        q_stride <= issue_stride;
        q_idx    <= issue_idx;
        q_add    <= issue_addend;
        pend     <= issue_mask;
        ret_r    <= '0;
        cnt      <= cnt + new_conf;
      end else if (busy_r) begin
        if (pend != '0) begin
          if (q_ret) ret_r[int'(cur)*DW +: DW] <= old_val;
          pend <= pend_next;
        end
        if (pend_next == '0) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
          retv_r <= q_ret;
        end
      end
    end
  end

  assign busy           = busy_r;
  assign done           = done_r;
  assign ret_valid      = retv_r;
  assign ret_data       = ret_r;
  assign conflict_count = cnt;
endmodule

module fadd_scatter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          busy,
  input logic          done,
  input logic          ret_valid,
  input logic [CW-1:0] conflict_count
);
  assert_done_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_retv_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> done);

  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy) |=> busy);

  assert_count_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && !busy) |=> $stable(conflict_count));
endmodule

bind fadd_scatter fadd_scatter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .busy(busy),
  .done(done), .ret_valid(ret_valid), .conflict_count(conflict_count));

// File: tb/tb_fadd_scatter.sv
module tb_fadd_scatter;
  localparam int LANES = 4, DW = 32, AW = 6, IW = 8, SW = 8, CW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, issue_ret = 0;
  logic [AW-1:0] issue_base = '0;
  logic [SW-1:0] issue_stride = '0;
  logic [LANES*IW-1:0] issue_idx = '0;
  logic [LANES*DW-1:0] issue_addend = '0;
  logic [LANES-1:0] issue_mask = '0;
  logic busy, done, ret_valid;
  logic [LANES*DW-1:0] ret_data;
  logic [CW-1:0] conflict_count;

  fadd_scatter dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [DW-1:0] mm [DEPTH];
  logic [CW-1:0] cnt_m = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int word_of(input int b, input int s, input int i);
    return (b + i * s) % DEPTH;
  endfunction

  task automatic do_op(input bit r, input int b, input int s,
                       input logic [LANES*IW-1:0] idxv, input logic [LANES*DW-1:0] addv,
                       input logic [LANES-1:0] m, input bit junk, input string req);
    int a [LANES];
    logic [LANES*DW-1:0] exp_ret;
    int k, inc, cyc;
    exp_ret = '0; k = 0; inc = 0;
    for (int l = 0; l < LANES; l++) a[l] = word_of(b, s, int'(idxv[l*IW +: IW]));
    for (int j = 0; j < LANES; j++) begin
      bit hit = 0;
      for (int i = 0; i < j; i++) if (m[i] && a[i] == a[j]) hit = 1;
      if (m[j] && hit) inc++;
    end
    for (int l = 0; l < LANES; l++) if (m[l]) begin
      k++;
      if (r) exp_ret[l*DW +: DW] = mm[a[l]];
      mm[a[l]] = mm[a[l]] + addv[l*DW +: DW];
    end
    cnt_m = cnt_m + CW'(inc);
    @(negedge clk);
    while (busy) @(negedge clk);
    issue_ret = r; issue_base = AW'(b); issue_stride = SW'(s);
    issue_idx = idxv; issue_addend = addv; issue_mask = m; issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      if (busy) cyc++;
      if (junk) begin
        issue_valid = busy; issue_ret = 1; issue_mask = '1;
        issue_addend = {LANES{32'h1111_0001}}; issue_base = AW'(b);
      end
      @(negedge clk);
    end
    issue_valid = 0;
    chk(cyc == ((k > 0) ? k : 1), "R6", "busy cycles", LANES*DW'(cyc), LANES*DW'((k > 0) ? k : 1));
    chk(ret_valid == r, r ? "R3" : "R4", "ret_valid", LANES*DW'(ret_valid), LANES*DW'(r));
    chk(ret_data == exp_ret, req, "ret_data", ret_data, exp_ret);
    chk(conflict_count == cnt_m, "R7", "conflict_count", LANES*DW'(conflict_count), LANES*DW'(cnt_m));
  endtask

  function automatic logic [LANES*IW-1:0] pk_idx(input int i0, i1, i2, i3);
    return {IW'(i3), IW'(i2), IW'(i1), IW'(i0)};
  endfunction

  function automatic logic [LANES*DW-1:0] pk_add(input logic [31:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  task automatic read_all(input string req);
    for (int g = 0; g < DEPTH; g += LANES)
      do_op(1, g, 1, pk_idx(0, 1, 2, 3), '0, '1, 0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !ret_valid, "R10", "flags after reset", {busy, done, ret_valid}, '0);
    chk(conflict_count == '0, "R10", "counter after reset", LANES*DW'(conflict_count), '0);
    read_all("R10");

    // R1 R3 distinct words, returning flavour
    do_op(1, 4, 2, pk_idx(0, 1, 2, 3), pk_add(5, 6, 7, 8), 4'hF, 0, "R1");
    do_op(1, 4, 2, pk_idx(0, 1, 2, 3), pk_add(1, 1, 1, 1), 4'hF, 0, "R3");
    // R4 plain flavour
    do_op(0, 20, 1, pk_idx(0, 1, 2, 3), pk_add(9, 9, 9, 9), 4'hF, 0, "R4");
    // R5 all lanes on one word
    do_op(1, 30, 0, pk_idx(1, 2, 3, 4), pk_add(10, 20, 30, 40), 4'hF, 0, "R5");
    do_op(1, 30, 1, pk_idx(0, 0, 7, 0), pk_add(1, 2, 3, 4), 4'hF, 0, "R5");
    // R2 masked lanes
    do_op(1, 40, 1, pk_idx(0, 0, 1, 0), pk_add(3, 100, 4, 200), 4'b0101, 0, "R2");
    do_op(1, 40, 1, pk_idx(0, 1, 2, 3), '0, 4'hF, 0, "R2");
    // R6 empty mask
    do_op(1, 0, 1, pk_idx(0, 1, 2, 3), pk_add(7, 7, 7, 7), 4'h0, 0, "R6");
    // R9 wrap of the sum
    do_op(1, 50, 1, pk_idx(0, 0, 1, 1), pk_add(32'hFFFF_FFFF, 32'h2, 32'h8000_0000, 32'h8000_0001), 4'hF, 0, "R9");
    // R1 address wrap: 60 + 5*3 = 75 -> 11
    do_op(1, 60, 3, pk_idx(5, 100, 0, 1), pk_add(11, 12, 13, 14), 4'hF, 0, "R1");
    // R8 offers during busy are ignored
    do_op(1, 44, 1, pk_idx(0, 1, 2, 3), pk_add(2, 2, 2, 2), 4'hF, 1, "R8");
    do_op(1, 44, 1, pk_idx(0, 1, 2, 3), '0, 4'hF, 0, "R8");

    // random, narrow indices to force collisions (R5 R7)
    for (int n = 0; n < 300; n++) begin
      logic [LANES*IW-1:0] iv;
      logic [LANES*DW-1:0] av;
      for (int l = 0; l < LANES; l++) begin
        iv[l*IW +: IW] = IW'($urandom % 4);
        av[l*DW +: DW] = $urandom;
      end
      do_op(1'($urandom), int'($urandom % DEPTH), int'($urandom % 3), iv, av,
            LANES'($urandom), 0, "R5");
    end
    read_all("R8");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule